// File: doc/BRIEF.md
# Segment Load Privilege Checker

This block rules on whether a segment selector may be placed into a segment register. Each request carries four things: the privilege level of the running code, the requested level held in the selector, the privilege level of the target descriptor, and a flag that is set when the destination is the stack segment register. Privilege levels are small unsigned numbers. Zero is the most trusted level and larger numbers are less trusted.

A valid request is sampled on a clock edge. On that same edge the block registers a single-cycle grant or refusal. A refusal also raises a general-protection fault pulse. For an ordinary data load, the less trusted of the current and requested levels is the effective level, and the descriptor must be no more trusted than that. Trusted code can therefore set the requested level to the least trusted value, and the access is then checked as if user code had made it. A stack register load is stricter: all three levels must be identical.

The block records the fields of the most recent refused request, so the fault handler can inspect them. Descriptor lookup, limit checks and type checks happen elsewhere. The descriptor level arrives here as an input.

Top module: `segload_guard`

## Requirements
- R1: A synchronous reset drives grant, refuse, gpFault and every recorded-fault field to zero.
- R2: On an edge where reqValid is low, grant, refuse and gpFault are low after that edge, and the recorded fields keep their values.
- R3: For a data load (stackTgt=0), the effective level is the numeric maximum of curLvl and reqLvl. The request is granted when descLvl >= effective level and refused otherwise.
- R4: For a stack load (stackTgt=1), the request is granted only when curLvl, reqLvl and descLvl are all equal. Any other combination is refused.
- R5: A data load whose reqLvl is the maximum level (all ones) is granted only when descLvl is also all ones, whatever curLvl is.
- R6: The decision for a request sampled at an edge appears right after that edge and lasts one cycle. A request held valid for consecutive edges gets a separate decision for each edge.
- R7: Each valid request produces exactly one of grant or refuse. The two are never high together.
- R8: gpFault is high in exactly the cycles in which refuse is high.
- R9: A refused request loads its curLvl, reqLvl, descLvl and stackTgt into lastCpl, lastRpl, lastDpl and lastStack on the decision edge. Granted requests leave these fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reqValid | input | 1 | Request strobe, sampled on the rising edge |
| curLvl | input | PRIV_W | Privilege level of running code |
| reqLvl | input | PRIV_W | Requested level carried in the selector |
| descLvl | input | PRIV_W | Privilege level of the target descriptor |
| stackTgt | input | 1 | Destination is the stack segment register |
| grant | output | 1 | Load allowed, one-cycle pulse |
| refuse | output | 1 | Load refused, one-cycle pulse |
| gpFault | output | 1 | General-protection fault pulse |
| lastCpl | output | PRIV_W | curLvl of the last refused request |
| lastRpl | output | PRIV_W | reqLvl of the last refused request |
| lastDpl | output | PRIV_W | descLvl of the last refused request |
| lastStack | output | 1 | stackTgt of the last refused request |

## Verification
The bench builds the block with the default PRIV_W of 2. At that width every combination of the three levels and the stack flag fits in 128 requests, so the whole decision table for both data and stack loads is swept and compared against a max-and-compare model. The small width also puts the all-ones requested level within reach of the sweep, along with the stack case where only one level differs. Idle cycles and back-to-back requests are run so the registered status can be seen to hold and to update correctly.

// File: rtl/segchk_pkg.sv
package segchk_pkg;
  // strobes issued by the control half to the datapath half
  typedef struct packed {
    logic issue;    // a request is being decided on this edge
    logic logDeny;  // the request on this edge is refused: record it
  } seg_strb_t;
endpackage

// File: rtl/segchk_datapath.sv
module segchk_datapath #(
  parameter int PRIV_W = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [PRIV_W-1:0]       curLvl,
  input  logic [PRIV_W-1:0]       reqLvl,
  input  logic [PRIV_W-1:0]       descLvl,
  input  logic                    stackTgt,
  input  segchk_pkg::seg_strb_t   strb,
  output logic                    passNow,
  output logic                    grant,
  output logic                    refuse,
  output logic [PRIV_W-1:0]       lastCpl,
  output logic [PRIV_W-1:0]       lastRpl,
  output logic [PRIV_W-1:0]       lastDpl,
  output logic                    lastStack
);
  logic [PRIV_W-1:0] effLvl;
  logic              stackOk;
  logic              dataOk;

  // the less trusted of the two levels is the numerically larger one
  always_comb effLvl  = (curLvl > reqLvl) ? curLvl : reqLvl;
  always_comb dataOk  = (descLvl >= effLvl);
  always_comb stackOk = (curLvl == reqLvl) && (reqLvl == descLvl);
  always_comb passNow = stackTgt ? stackOk : dataOk;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant  <= 1'b0;
      refuse <= 1'b0;
    end else begin
      grant  <= strb.issue & passNow;
      refuse <= strb.issue & ~passNow;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lastCpl   <= '0;
      lastRpl   <= '0;
      lastDpl   <= '0;
      lastStack <= 1'b0;
    end else if (strb.logDeny) begin
      lastCpl   <= curLvl;
      lastRpl   <= reqLvl;
      lastDpl   <= descLvl;
      lastStack <= stackTgt;
    end
  end

  // R7: never both answers at once
  a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
    $onehot0({grant, refuse}));

  // R7: an issued request always gets an answer
  a_r7_answered: assert property (@(posedge clk) disable iff (rst)
    strb.issue |=> (grant || refuse));

  // R9: status holds when nothing is refused
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    !strb.logDeny |=> ($stable(lastCpl) && $stable(lastRpl) &&
                       $stable(lastDpl) && $stable(lastStack)));
endmodule

// File: rtl/segchk_ctrl.sv
module segchk_ctrl (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  reqValid,
  input  logic                  passNow,
  output segchk_pkg::seg_strb_t strb,
  output logic                  gpFault
);
  always_comb begin
    strb.issue   = reqValid;
    strb.logDeny = reqValid & ~passNow;
  end

  always_ff @(posedge clk) begin
    if (rst) gpFault <= 1'b0;
    else     gpFault <= strb.logDeny;
  end

  // R2: idle edge leaves no fault behind
  a_r2_idle_nofault: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> !gpFault);

  // R6: a fault is a single pulse unless a new refused request follows
  a_r6_pulse: assert property (@(posedge clk) disable iff (rst)
    (gpFault && !strb.logDeny) |=> !gpFault);
endmodule

// File: rtl/segload_guard.sv
module segload_guard #(
  parameter int PRIV_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reqValid,
  input  logic [PRIV_W-1:0] curLvl,
  input  logic [PRIV_W-1:0] reqLvl,
  input  logic [PRIV_W-1:0] descLvl,
  input  logic              stackTgt,
  output logic              grant,
  output logic              refuse,
  output logic              gpFault,
  output logic [PRIV_W-1:0] lastCpl,
  output logic [PRIV_W-1:0] lastRpl,
  output logic [PRIV_W-1:0] lastDpl,
  output logic              lastStack
);
  localparam logic [PRIV_W-1:0] LEAST_TRUSTED = '1;

  segchk_pkg::seg_strb_t strb;
  logic                  passNow;

  segchk_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .reqValid (reqValid),
    .passNow  (passNow),
    .strb     (strb),
    .gpFault  (gpFault)
  );

  segchk_datapath #(.PRIV_W(PRIV_W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .curLvl    (curLvl),
    .reqLvl    (reqLvl),
    .descLvl   (descLvl),
    .stackTgt  (stackTgt),
    .strb      (strb),
    .passNow   (passNow),
    .grant     (grant),
    .refuse    (refuse),
    .lastCpl   (lastCpl),
    .lastRpl   (lastRpl),
    .lastDpl   (lastDpl),
    .lastStack (lastStack)
  );

  // R8: fault and refusal travel together
  a_r8_fault_match: assert property (@(posedge clk) disable iff (rst)
    gpFault == refuse);

  // R4: mismatched stack load is refused
  a_r4_stack_mismatch: assert property (@(posedge clk) disable iff (rst)
    (reqValid && stackTgt && ((curLvl != reqLvl) || (reqLvl != descLvl)))
    |=> refuse);

  // R3: a descriptor more trusted than the caller is refused on a data load
  a_r3_data_refuse: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !stackTgt && ((descLvl < curLvl) || (descLvl < reqLvl)))
    |=> refuse);

  // R5: a least-trusted requested level needs a least-trusted descriptor
  a_r5_forced_user: assert property (@(posedge clk) disable iff (rst)
    (reqValid && !stackTgt && (reqLvl == LEAST_TRUSTED) &&
     (descLvl != LEAST_TRUSTED)) |=> refuse);

  // R2: idle edge yields no answer
  a_r2_idle: assert property (@(posedge clk) disable iff (rst)
    !reqValid |=> (!grant && !refuse));
endmodule

// File: tb/tb_segload_guard.sv
`timescale 1ns/1ps
module tb_segload_guard;
  localparam int W = 2;
  localparam int NLVL = 1 << W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqValid = 1'b0;
  logic [W-1:0] curLvl = '0, reqLvl = '0, descLvl = '0;
  logic stackTgt = 1'b0;
  logic grant, refuse, gpFault, lastStack;
  logic [W-1:0] lastCpl, lastRpl, lastDpl;

  int applied = 0;
  int bad = 0;
  bit done = 0;

  // model of the recorded fields
  logic [W-1:0] mCpl = '0, mRpl = '0, mDpl = '0;
  logic mStack = 1'b0;

  always #2.5 clk = ~clk;

  segload_guard #(.PRIV_W(W)) dut (
    .clk(clk), .rst(rst), .reqValid(reqValid),
    .curLvl(curLvl), .reqLvl(reqLvl), .descLvl(descLvl), .stackTgt(stackTgt),
    .grant(grant), .refuse(refuse), .gpFault(gpFault),
    .lastCpl(lastCpl), .lastRpl(lastRpl), .lastDpl(lastDpl), .lastStack(lastStack)
  );

  task automatic check(input string req, input logic [2:0] got, input logic [2:0] exp);
    applied++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: {grant,refuse,gpFault} got %b expected %b", req, got, exp);
    end
  endtask

  task automatic checkStatus(input string req);
    applied++;
    if ({lastCpl, lastRpl, lastDpl, lastStack} !== {mCpl, mRpl, mDpl, mStack}) begin
      bad++;
      $display("FAIL %s: status got %h/%h/%h/%b expected %h/%h/%h/%b", req,
               lastCpl, lastRpl, lastDpl, lastStack, mCpl, mRpl, mDpl, mStack);
    end
  endtask

  function automatic bit expPass(int c, int r, int d, bit s);
    int eff;
    eff = (c > r) ? c : r;
    if (s) return (c == r) && (r == d);
    return d >= eff;
  endfunction

  function automatic string tagFor(int c, int r, int d, bit s);
    if (s) return "R4";
    if (r == NLVL - 1) return "R5";
    return "R3";
  endfunction

  // drive one request at a negedge, check after the following edge
  task automatic oneReq(int c, int r, int d, bit s);
    bit p;
    p = expPass(c, r, d, s);
    curLvl = W'(c); reqLvl = W'(r); descLvl = W'(d); stackTgt = s;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    if (!p) begin mCpl = W'(c); mRpl = W'(r); mDpl = W'(d); mStack = s; end
    check(tagFor(c, r, d, s), {grant, refuse, gpFault}, {p, !p, !p});
    checkStatus("R9");
    @(negedge clk);
    check("R6", {grant, refuse, gpFault}, 3'b000);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: run did not finish");
      $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1", {grant, refuse, gpFault}, 3'b000);
    checkStatus("R1");

    // full sweep of both load kinds
    for (int s = 0; s < 2; s++)
      for (int c = 0; c < NLVL; c++)
        for (int r = 0; r < NLVL; r++)
          for (int d = 0; d < NLVL; d++)
            oneReq(c, r, d, s[0]);

    // R2: idle with refusing inputs present changes nothing
    for (int k = 0; k < NLVL; k++) begin
      curLvl = W'(NLVL - 1); reqLvl = W'(k); descLvl = '0; stackTgt = k[0];
      reqValid = 1'b0;
      @(negedge clk);
      check("R2", {grant, refuse, gpFault}, 3'b000);
      checkStatus("R2");
    end

    // R6: back-to-back requests, refuse then grant then refuse
    curLvl = 2'd3; reqLvl = 2'd0; descLvl = 2'd1; stackTgt = 1'b0; reqValid = 1'b1;
    @(negedge clk);
    mCpl = 2'd3; mRpl = 2'd0; mDpl = 2'd1; mStack = 1'b0;
    check("R6", {grant, refuse, gpFault}, 3'b011);
    curLvl = 2'd1; reqLvl = 2'd1; descLvl = 2'd1; stackTgt = 1'b1;
    @(negedge clk);
    check("R6", {grant, refuse, gpFault}, 3'b100);
    checkStatus("R9");
    curLvl = 2'd0; reqLvl = 2'd2; descLvl = 2'd2; stackTgt = 1'b1;
    @(negedge clk);
    mCpl = 2'd0; mRpl = 2'd2; mDpl = 2'd2; mStack = 1'b1;
    check("R8", {grant, refuse, gpFault}, 3'b011);
    checkStatus("R9");
    reqValid = 1'b0;
    @(negedge clk);
    check("R6", {grant, refuse, gpFault}, 3'b000);

    // R1: reset mid-run clears status
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    mCpl = '0; mRpl = '0; mDpl = '0; mStack = 1'b0;
    check("R1", {grant, refuse, gpFault}, 3'b000);
    checkStatus("R1");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", applied, bad);
    $finish;
  end
endmodule